// File: doc/BRIEF.md
# Six-Channel Shadow-Reload Pulse-Width Modulator

This block provides a bank of independent pulse-width channels behind a small register interface. The interface has a one-cycle write strobe and a one-cycle read strobe. Each channel counts clock cycles. It holds a period count and an active-phase count, and it drives one output pin. Software writes the period and the active count into shadow registers. Those values reach the running counter only when a load control bit goes from 0 to 1. If the channel is idle the transfer happens at once. If the channel is running the transfer waits for the end of the current period, so no period is ever cut short. A separate go bit starts the channel on a 0-to-1 write. The go bit clears itself once the channel is running, and writing it back to 0 does not stop the channel. An active count of zero keeps the pin at its inactive level, and software uses that to switch a channel off.

The output polarity can be chosen freely until the channel first starts. After that it stays fixed until a soft reset. Each channel is a small two-state machine. In `CH_IDLE` the counter is held and the pin sits at the inactive level. The transition `START` (go written from 0 to 1 while idle) moves the channel to `CH_RUN`, where the counter wraps every period. The transition `SRST` (a soft-reset write while running) returns it to `CH_IDLE`. Interrupt enable, event trigger, mode and idle-level fields, and a repeat word, are stored and read back but have no effect on the output.

Top module: `pwmb_bank`

## Requirements
- R1: Channel n occupies the byte window starting at n*0x20 (n = 0..5). Within a window the registers are: control at 0x00, period at 0x04, active count at 0x08, status at 0x0C, repeat word at 0x10. Read data appears on `rdata` in the cycle after `rd_en`. A read of any other address (a higher window, an unused offset, or an address that is not word-aligned) returns 0, and a write to such an address changes nothing.
- R2: The control register fields are: bit 0 go, bit 1 load, bit 2 soft reset, bit 3 polarity, bits 5:4 mode, bits 7:6 trigger select, bit 8 interrupt enable, bit 9 idle level. Mode, trigger, interrupt enable, idle level and the repeat word are stored and read back unchanged, and they do not affect the output.
- R3: A running channel with period P and active count D drives its pin active for the first D cycles of every P-cycle period, starting in the cycle right after the edge that captures the go write. D = 0 gives no active cycle. D >= P keeps the pin active for the whole period.
- R4: A polarity bit of 1 makes the active level high. A polarity bit of 0 makes it low. The inactive level is the inverse of the active level, and an idle channel drives the inactive level.
- R5: A channel starts only when a control write takes the go bit from 0 to 1 while the channel is idle. A later write of 0 to go does not stop a running channel.
- R6: The go bit reads back as 0 once the channel is running.
- R7: Shadow period and active count are copied together only when a control write takes the load bit from 0 to 1. Writing 1 while the bit already reads 1 causes no copy. On an idle channel the copy happens immediately.
- R8: On a running channel a requested copy is held and applied at the end of the current period.
- R9: After the channel has started, writes to the polarity bit are ignored until a soft reset.
- R10: A control write with the soft-reset bit set stops the channel and clears the counter, the status, any held copy, the started flag, go and load. The pin returns to the inactive level. No other field of that write is stored, and the soft-reset bit always reads 0.
- R11: Status bits 7:0 count completed periods modulo 256.
- R12: After reset, every register reads 0 except the polarity bit, which reads 1, and every pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| pwm_out | output | 6 | One pulse-width output per channel |

## Verification
A write is captured on the rising edge where `wr_en` is high, so a go write takes effect at that edge. The pin then shows counter value k in the half-cycle that follows the k-th edge after it. The bench therefore samples each pin at falling edges and indexes every sample by that k. It issues later writes in consecutive cycles so that the capture edge of a load request lands at a known k, and it expects a held copy to appear exactly at k = P. Status is read as `floor(j/P)` when the read is issued j cycles after the start, because the registered read samples the count as it stood one edge earlier.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef enum logic [2:0] {
        RG_CTRL = 3'd0,
        RG_PER  = 3'd1,
        RG_DUTY = 3'd2,
        RG_STAT = 3'd3,
        RG_RPT  = 3'd4
    } reg_sel_e;

    localparam int unsigned B_GO   = 0;
    localparam int unsigned B_LOAD = 1;
    localparam int unsigned B_SRST = 2;
    localparam int unsigned B_POL  = 3;
    localparam int unsigned B_MODE = 4;
    localparam int unsigned B_TRIG = 6;
    localparam int unsigned B_IRQ  = 8;
    localparam int unsigned B_IDLE = 9;
endpackage

// File: rtl/pwmb_decode.sv
module pwmb_decode #(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8,
    parameter int CH_W   = 3
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   wr_en,
    output logic                   hit,
    output logic [CH_W-1:0]        ch_idx,
    output pwmb_pkg::reg_sel_e     sel,
    output logic [NUM_CH-1:0]      ch_wr
);
    localparam int WIN_W = ADDR_W - 5;
    localparam logic [WIN_W-1:0] LAST_WIN = WIN_W'(NUM_CH - 1);

    logic [WIN_W-1:0] win;

    assign win    = addr[ADDR_W-1:5];
    assign ch_idx = win[CH_W-1:0];
    assign sel    = pwmb_pkg::reg_sel_e'(addr[4:2]);
    assign hit    = (win <= LAST_WIN) && (addr[1:0] == 2'b00) && (addr[4:2] <= 3'd4);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
        assign ch_wr[i] = wr_en && hit && (ch_idx == CH_W'(i));
    end
endmodule

// File: rtl/pwmb_chan.sv
module pwmb_chan #(
    parameter int DATA_W = 32,
    parameter int STAT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  pwmb_pkg::reg_sel_e sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_word,
    output logic               pwm_o,
    output logic               run_o,
    output logic               ever_o,
    output logic               pol_o,
    output logic               go_o,
    output logic               pend_o
);
    import pwmb_pkg::*;

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    ch_state_e         state_q, state_d;
    logic              go_q, load_q, pol_q, irq_q, idle_q, ever_q, pend_q;
    logic [1:0]        mode_q, trig_q;
    logic [DATA_W-1:0] per_sh, duty_sh, per_act, duty_act, cnt_q, rpt_q;
    logic [STAT_W-1:0] stat_q;

    logic wr_ctl, srst, go_rise, load_rise, running, at_end, active;

    assign wr_ctl    = wr && (sel == RG_CTRL);
    assign srst      = wr_ctl && wdata[B_SRST];
    assign go_rise   = wr_ctl && !srst && wdata[B_GO] && !go_q;
    assign load_rise = wr_ctl && !srst && wdata[B_LOAD] && !load_q;
    assign running   = (state_q == CH_RUN);
    assign at_end    = running && ((per_act <= ONE) || (cnt_q >= per_act - ONE));
    assign active    = running && (cnt_q < duty_act);

    // next-state logic: START and SRST transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (go_rise) state_d = CH_RUN;
            CH_RUN:  if (srst)    state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q <= 1'b0; load_q <= 1'b0; pol_q <= 1'b1; irq_q <= 1'b0;
            idle_q <= 1'b0; ever_q <= 1'b0; pend_q <= 1'b0;
            mode_q <= '0; trig_q <= '0; per_sh <= '0; duty_sh <= '0;
            per_act <= '0; duty_act <= '0; cnt_q <= '0; rpt_q <= '0; stat_q <= '0;
        end else begin
            if (wr && sel == RG_PER)  per_sh  <= wdata;
            if (wr && sel == RG_DUTY) duty_sh <= wdata;
            if (wr && sel == RG_RPT)  rpt_q   <= wdata;
            if (srst) begin
                cnt_q <= '0; stat_q <= '0; pend_q <= 1'b0;
                ever_q <= 1'b0; go_q <= 1'b0; load_q <= 1'b0;
            end else begin
                if (wr_ctl) begin
                    go_q   <= wdata[B_GO];
                    load_q <= wdata[B_LOAD];
                    mode_q <= wdata[B_MODE +: 2];
                    trig_q <= wdata[B_TRIG +: 2];
                    irq_q  <= wdata[B_IRQ];
                    idle_q <= wdata[B_IDLE];
                    if (!ever_q) pol_q <= wdata[B_POL];
                end
                if (running) go_q <= 1'b0;
                if (go_rise && !running) begin
                    ever_q <= 1'b1;
                    cnt_q  <= '0;
                end
                if (load_rise && !running) begin
                    per_act  <= per_sh;
                    duty_act <= duty_sh;
                end else if (load_rise) begin
                    pend_q <= 1'b1;
                end
                if (at_end) begin
                    cnt_q  <= '0;
                    stat_q <= stat_q + 1'b1;
                    if (pend_q || load_rise) begin
                        per_act  <= per_sh;
                        duty_act <= duty_sh;
                        pend_q   <= 1'b0;
                    end
                end else if (running) begin
                    cnt_q <= cnt_q + ONE;
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (sel)
            RG_CTRL: begin
                rd_word[B_GO]         = go_q;
                rd_word[B_LOAD]       = load_q;
                rd_word[B_POL]        = pol_q;
                rd_word[B_MODE +: 2]  = mode_q;
                rd_word[B_TRIG +: 2]  = trig_q;
                rd_word[B_IRQ]        = irq_q;
                rd_word[B_IDLE]       = idle_q;
            end
            RG_PER:  rd_word = per_sh;
            RG_DUTY: rd_word = duty_sh;
            RG_STAT: rd_word[STAT_W-1:0] = stat_q;
            RG_RPT:  rd_word = rpt_q;
            default: rd_word = '0;
        endcase
    end

    assign pwm_o  = active ? pol_q : ~pol_q;
    assign run_o  = running;
    assign ever_o = ever_q;
    assign pol_o  = pol_q;
    assign go_o   = go_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/pwmb_bank.sv
module pwmb_bank #(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic               hit;
    logic [CH_W-1:0]    ch_idx;
    pwmb_pkg::reg_sel_e sel;
    logic [NUM_CH-1:0]  ch_wr, run_vec, ever_vec, pol_vec, go_vec, pend_vec;
    logic [DATA_W-1:0]  rd_words [NUM_CH];

    pwmb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
        .addr(addr), .wr_en(wr_en), .hit(hit), .ch_idx(ch_idx), .sel(sel), .ch_wr(ch_wr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwmb_chan #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr(ch_wr[i]), .sel(sel), .wdata(wdata),
            .rd_word(rd_words[i]), .pwm_o(pwm_out[i]), .run_o(run_vec[i]),
            .ever_o(ever_vec[i]), .pol_o(pol_vec[i]), .go_o(go_vec[i]), .pend_o(pend_vec[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= hit ? rd_words[ch_idx] : '0;
    end
endmodule

// File: rtl/pwmb_bank_chk.sv
module pwmb_bank_chk #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] run_vec,
    input logic [NUM_CH-1:0] ever_vec,
    input logic [NUM_CH-1:0] pol_vec,
    input logic [NUM_CH-1:0] go_vec,
    input logic [NUM_CH-1:0] pend_vec
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        a_r9_pol_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (ever_vec[i] && $past(ever_vec[i])) |-> (pol_vec[i] == $past(pol_vec[i])));
        a_r6_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (go_vec[i] && run_vec[i]) |=> !go_vec[i]);
        a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run_vec[i] |-> (pwm_out[i] == !pol_vec[i]));
        a_r8_pend_running: assert property (@(posedge clk) disable iff (!rst_n)
            pend_vec[i] |-> run_vec[i]);
        a_r5_start_marks: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_vec[i]) |-> ever_vec[i]);
        a_r10_stop_srst: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run_vec[i]) |-> !ever_vec[i]);
    end
endmodule

bind pwmb_bank pwmb_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .run_vec(run_vec),
    .ever_vec(ever_vec), .pol_vec(pol_vec), .go_vec(go_vec), .pend_vec(pend_vec)
);

// File: tb/sim_pwmb_bank.sv
module sim_pwmb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  pwm_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    pwmb_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                  .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // soft reset, load immediately while idle, then start; returns at sample k=0
    task automatic start_ch(input int ch, input int per, input int duty, input bit pol);
        logic [7:0] b;
        b = 8'(ch * 32);
        wr(b, 32'h4);
        wr(b + 8'h04, 32'(per));
        wr(b + 8'h08, 32'(duty));
        wr(b, {28'd0, pol, 3'b010});
        wr(b, {28'd0, pol, 3'b011});
    endtask

    task automatic sweep_one(input int ch, input int per, input int duty, input bit pol);
        int bad;
        bit e;
        bad = 0;
        start_ch(ch, per, duty, pol);
        for (int k = 0; k < 2 * per + 2; k++) begin
            e = ((k % per) < duty) ? pol : !pol;
            if (pwm_out[ch] !== e) bad++;
            @(negedge clk);
        end
        chk(bad == 0, $sformatf("R3/R4 ch%0d per=%0d duty=%0d pol=%0d mismatches", ch, per, duty, pol),
            32'(bad), 32'd0);
    endtask

    function automatic int count_hi(input logic [5:0] dummy);
        return 0;
    endfunction

    initial begin
        logic [31:0] d;
        int idx, hi, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk(pwm_out == 6'd0, "R12 pins low after reset", 32'(pwm_out), 32'd0);
        rd(8'h00, d); chk(d == 32'h8, "R12 control reset value", d, 32'h8);
        rd(8'h64, d); chk(d == 32'h0, "R12 period reset value", d, 32'h0);
        // R1 unmapped reads
        rd(8'hC0, d); chk(d == 32'h0, "R1 read beyond last window", d, 32'h0);
        rd(8'h14, d); chk(d == 32'h0, "R1 read unused offset", d, 32'h0);
        wr(8'hC4, 32'h55);
        rd(8'h44, d); chk(d == 32'h0, "R1 write to unmapped window ignored", d, 32'h0);

        // R3 R4 R7 sweep
        idx = 0;
        for (int per = 1; per <= 4; per++)
            for (int duty = 0; duty <= per + 1; duty++)
                for (int pol = 0; pol < 2; pol++) begin
                    sweep_one(idx % 6, per, duty, pol[0]);
                    idx++;
                end

        // R6 go reads 0 once running, R9 polarity lock
        start_ch(2, 4, 1, 1'b1);
        repeat (2) @(negedge clk);
        rd(8'h40, d); chk(d == 32'hA, "R6 go self-cleared", d, 32'hA);
        wr(8'h40, 32'h2);
        rd(8'h40, d); chk(d[3] == 1'b1, "R9 polarity write ignored", 32'(d[3]), 32'd1);
        hi = 0;
        for (int k = 0; k < 8; k++) begin hi += int'(pwm_out[2]); @(negedge clk); end
        chk(hi == 2, "R9 R5 still active-high and running after go=0 write", 32'(hi), 32'd2);

        // R11 status, R10 soft reset
        start_ch(4, 4, 2, 1'b1);
        repeat (13) @(negedge clk);
        rd(8'h8C, d); chk(d == 32'd3, "R11 completed periods", d, 32'd3);
        wr(8'h80, 32'hFFC);
        chk(pwm_out[4] == 1'b0, "R10 pin inactive after soft reset", 32'(pwm_out[4]), 32'd0);
        rd(8'h8C, d); chk(d == 32'd0, "R10 status cleared", d, 32'd0);
        rd(8'h80, d); chk(d == 32'h8, "R10 other fields not stored", d, 32'h8);

        // R2 stored fields and R1 register placement
        wr(8'h20, 32'h4);
        wr(8'h20, 32'h3E8);
        rd(8'h20, d); chk(d == 32'h3E8, "R2 stored control fields", d, 32'h3E8);
        chk(pwm_out[1] == 1'b0, "R2 stored fields do not drive pin", 32'(pwm_out[1]), 32'd0);
        wr(8'h30, 32'h12345678);
        rd(8'h30, d); chk(d == 32'h12345678, "R1 repeat word readback", d, 32'h12345678);
        wr(8'h24, 32'hDEADBEEF);
        rd(8'h24, d); chk(d == 32'hDEADBEEF, "R1 period readback", d, 32'hDEADBEEF);

        // R8 held copy applied at period end; R7 no copy without a rising load
        start_ch(3, 10, 10, 1'b1);
        wr(8'h68, 32'd0);
        wr(8'h60, 32'h8);
        wr(8'h60, 32'hA);
        bad = 0;
        for (int k = 3; k < 20; k++) begin
            if (pwm_out[3] !== (k < 10)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R8 copy waits for period end", 32'(bad), 32'd0);
        wr(8'h68, 32'd10);
        wr(8'h60, 32'hA);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            if (pwm_out[3] !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R7 load already 1 makes no copy", 32'(bad), 32'd0);
        wr(8'h60, 32'h8);
        wr(8'h60, 32'hA);
        repeat (11) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            if (pwm_out[3] !== 1'b1) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R7 re-armed load copies", 32'(bad), 32'd0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule